// File: doc/BRIEF.md
# Memory Wait-State Generator

This block sits beside a processor that runs from a free-running clock and drives the processor's active-low wait input. The wait input lets slow memory stretch an access without stretching the clock itself. When an access starts, the generator looks at the top address bits to pick one of several memory regions. Each region has its own programmable number of stall periods, and the generator holds wait low for that many clock periods.

A slow device can also push the access out further through a ready input. Once the programmed count has run out, wait stays low for as long as ready is sampled low. There is no upper limit on this extension. Holding wait low has the same effect as lengthening the low phase of the clock. Because the low phase is the one that gets stretched, a memory manager can still abort an access that turns out to fail.

All state, including the wait output, is updated on the falling clock edge. The wait output therefore only ever changes while the clock is low. The reset is synchronous, active high and sampled on that same falling edge.

Top module: `wsg_top`

## Requirements
- R1: `wait_n_o` changes only at a falling edge of `clk`, and is stable throughout every high phase.
- R2: An access starts when the block is idle (wait high) and `acc_valid_i` is sampled high at a falling edge. If the selected count N is 1 to 15 and `ready_i` is high when the count runs out, wait goes low at that edge. It then stays low for exactly N clock periods and rises at the N-th following falling edge.
- R3: An access whose region count is 0 and which sees `ready_i` high at its start edge leaves `wait_n_o` high, so no cycle is added.
- R4: After the count has run out (or at the start edge, for a count of 0), wait stays low until the first falling edge at which `ready_i` is high, and rises at that edge. There is no bound on the length of the stall. `ready_i` has no effect while the count is still running.
- R5: While a stall is in progress, `acc_valid_i` and `addr_top_i` are ignored and neither restarts nor extends the stall.
- R6: The region number is `addr_top_i` (address bits [31:30]). The count of region r is `region_wait_i[4r+3:4r]`.
- R7: While `rst` is sampled high at a falling edge, `wait_n_o` is set high and any stall in progress is dropped.
- R8: The falling edge right after the one that releases wait may start a new access, so back-to-back accesses need no idle period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running processor clock; all state changes on its falling edge |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge |
| acc_valid_i | input | 1 | High when the processor presents a new access this cycle |
| addr_top_i | input | 2 | Upper address bits that select the region |
| region_wait_i | input | 16 | Four 4-bit stall counts, region r in bits [4r+3:4r] |
| ready_i | input | 1 | Slow-device ready; low extends a stall after its count runs out |
| wait_n_o | output | 1 | Active-low wait to the processor, registered on the falling edge |

## Verification
Single accesses are driven into each region with ready held high. This separates the zero, short, long and one-period counts and exposes a wrong field decode. Ready is then held low for several lengths, both shorter and longer than the count. This shows whether ready extends the stall only after the count has run out and not while it is still running. Holding the access strobe high through a stall, and running accesses back to back, separates "ignored while busy" from "restarted". A reset in the middle of a stall, followed by a long mixed stream of accesses, addresses and ready values, is compared period by period against a behavioural model in the bench.

// File: rtl/wsg_pkg.sv
package wsg_pkg;
  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_STALL = 1'b1
  } wsg_state_e;
endpackage

// File: rtl/wsg_region_sel.sv
module wsg_region_sel #(
  parameter int REGION_BITS = 2,
  parameter int CNT_W       = 4,
  localparam int NREG       = 1 << REGION_BITS
) (
  input  logic [REGION_BITS-1:0] region_i,
  input  logic [NREG*CNT_W-1:0]  table_i,
  output logic [CNT_W-1:0]       count_o
);
  logic [CNT_W-1:0] slot [NREG];

  // R6: region r owns field [r*CNT_W +: CNT_W]
  for (genvar g = 0; g < NREG; g++) begin : g_slot
    assign slot[g] = table_i[g*CNT_W +: CNT_W];
  end

  assign count_o = slot[region_i];
endmodule

// File: rtl/wsg_stall_ctr.sv
module wsg_stall_ctr
  import wsg_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] load_cnt_i,
  input  logic             ready_i,
  output logic             wait_n_o
);
  wsg_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             wait_n_q;
  logic             rst_d_q;

  // falling-edge registers keep every wait change inside the low phase (R1)
  always_ff @(negedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      wait_n_q <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i && ((load_cnt_i != '0) || !ready_i)) begin
            state_q  <= ST_STALL;
            wait_n_q <= 1'b0;
            cnt_q    <= (load_cnt_i == '0) ? '0 : load_cnt_i - 1'b1;
          end
        end
        ST_STALL: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (ready_i) begin
            state_q  <= ST_IDLE;
            wait_n_q <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wait_n_o = wait_n_q;

  always_ff @(negedge clk) rst_d_q <= rst;

  always @(negedge clk) begin
    if (rst_d_q) begin
      AST_RESET_HIGH: assert (wait_n_q) else $error("wait low after reset"); // R7
    end
  end

  AST_LOAD_STALL: assert property (@(negedge clk) disable iff (rst)
    (wait_n_q && start_i && load_cnt_i != '0)
      |=> (!wait_n_q && cnt_q == CNT_W'($past(load_cnt_i) - 1'b1))) else $error("load"); // R2
  AST_COUNT_HOLD: assert property (@(negedge clk) disable iff (rst)
    (!wait_n_q && cnt_q != '0) |=> !wait_n_q) else $error("count hold"); // R2
  AST_ZERO_PASS: assert property (@(negedge clk) disable iff (rst)
    (wait_n_q && start_i && load_cnt_i == '0 && ready_i) |=> wait_n_q) else $error("zero"); // R3
  AST_READY_HOLD: assert property (@(negedge clk) disable iff (rst)
    (!wait_n_q && !ready_i) |=> !wait_n_q) else $error("ready hold"); // R4
  AST_RELEASE: assert property (@(negedge clk) disable iff (rst)
    (!wait_n_q && cnt_q == '0 && ready_i) |=> wait_n_q) else $error("release"); // R4
  AST_BUSY_IGNORE: assert property (@(negedge clk) disable iff (rst)
    (!wait_n_q && cnt_q != '0) |=> (cnt_q == CNT_W'($past(cnt_q) - 1'b1))) else $error("busy"); // R5
endmodule

// File: rtl/wsg_top.sv
module wsg_top #(
  parameter int REGION_BITS = 2,
  parameter int CNT_W       = 4,
  localparam int NREG       = 1 << REGION_BITS
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid_i,
  input  logic [REGION_BITS-1:0] addr_top_i,
  input  logic [NREG*CNT_W-1:0]  region_wait_i,
  input  logic                   ready_i,
  output logic                   wait_n_o
);
  logic [CNT_W-1:0] sel_cnt;

  wsg_region_sel #(
    .REGION_BITS(REGION_BITS),
    .CNT_W      (CNT_W)
  ) u_sel (
    .region_i(addr_top_i),
    .table_i (region_wait_i),
    .count_o (sel_cnt)
  );

  wsg_stall_ctr #(
    .CNT_W(CNT_W)
  ) u_ctr (
    .clk       (clk),
    .rst       (rst),
    .start_i   (acc_valid_i),
    .load_cnt_i(sel_cnt),
    .ready_i   (ready_i),
    .wait_n_o  (wait_n_o)
  );
endmodule

// File: tb/sim_wsg_top.sv
`timescale 1ns/1ps
module sim_wsg_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        acc_valid;
  logic [1:0]  addr_top;
  logic [15:0] region_wait;
  logic        ready;
  logic        wait_n;

  always #2.5 clk = ~clk;

  wsg_top u0 (
    .clk          (clk),
    .rst          (rst),
    .acc_valid_i  (acc_valid),
    .addr_top_i   (addr_top),
    .region_wait_i(region_wait),
    .ready_i      (ready),
    .wait_n_o     (wait_n)
  );

  int    total = 0;
  int    bad   = 0;
  string cur_req = "R7";
  bit    mon_on = 1'b0;
  bit    done = 1'b0;

  // behavioural reference: busy flag, periods elapsed, periods needed
  bit m_busy = 1'b0;
  int m_elapsed = 0;
  int m_need = 0;

  function automatic int cfg_of(int r);
    return int'((region_wait >> (4 * r)) & 16'hF);
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst) m_busy = 1'b0;
    else if (!m_busy) begin
      if (acc_valid && (cfg_of(int'(addr_top)) > 0 || !ready)) begin
        m_busy = 1'b1;
        m_need = cfg_of(int'(addr_top));
        m_elapsed = 0;
      end
    end else begin
      m_elapsed++;
      if (m_elapsed >= m_need && ready) m_busy = 1'b0;
    end
  end

  // per-clock comparison, plus a mid-high-phase stability check (R1)
  always @(posedge clk) begin
    if (mon_on && !done) begin
      logic w1;
      #0.2;
      w1 = wait_n;
      check(w1 === !m_busy, cur_req, int'(w1), int'(!m_busy));
      #1.8;
      check(wait_n === w1, "R1", int'(wait_n), int'(w1));
    end
  end

  // one access; ready held low for k periods; expect exp_lows low samples
  task automatic run_access(int r, int k, int exp_lows, string req);
    int lows = 0;
    @(posedge clk); #0.5;
    acc_valid = 1'b1;
    addr_top  = 2'(r);
    ready     = (k > 0) ? 1'b0 : 1'b1;
    for (int cyc = 1; cyc <= 40; cyc++) begin
      @(posedge clk); #0.2;
      if (wait_n === 1'b0) lows++;
      #0.3;
      if (cyc == 1) acc_valid = 1'b0;
      if (cyc == k) ready = 1'b1;
    end
    check(lows == exp_lows, req, lows, exp_lows);
  endtask

  initial begin
    rst = 1'b1; acc_valid = 1'b0; addr_top = 2'd0; ready = 1'b1;
    region_wait = {4'd1, 4'd15, 4'd3, 4'd0};
    repeat (2) @(posedge clk);
    mon_on = 1'b1;
    repeat (2) @(posedge clk);
    #0.2;
    check(wait_n === 1'b1, "R7", int'(wait_n), 1);
    #0.3; rst = 1'b0;

    cur_req = "R3"; run_access(0, 0, 0, "R3");
    cur_req = "R2"; run_access(1, 0, 3, "R2");
    cur_req = "R6"; run_access(2, 0, 15, "R6");
    run_access(3, 0, 1, "R6");
    cur_req = "R4"; run_access(1, 9, 9, "R4");
    run_access(0, 5, 5, "R4");
    run_access(2, 4, 15, "R4");
    run_access(3, 30, 30, "R4");

    // R5: strobe held high with another region through a long stall
    cur_req = "R5";
    @(posedge clk); #0.5;
    acc_valid = 1'b1; addr_top = 2'd2;
    @(posedge clk); #0.5;
    addr_top = 2'd1;
    begin
      int lows = 0;
      for (int i = 0; i < 14; i++) begin
        @(posedge clk); #0.2;
        if (wait_n === 1'b0) lows++;
      end
      check(lows == 14, "R5", lows, 14);
    end
    #0.3; acc_valid = 1'b0;
    repeat (6) @(posedge clk);

    // R8: back-to-back single-period accesses
    cur_req = "R8";
    begin
      int lows = 0;
      @(posedge clk); #0.5;
      acc_valid = 1'b1; addr_top = 2'd3;
      for (int i = 0; i < 10; i++) begin
        @(posedge clk); #0.2;
        if (wait_n === 1'b0) lows++;
      end
      check(lows == 5, "R8", lows, 5);
      #0.3; acc_valid = 1'b0;
    end
    repeat (4) @(posedge clk);

    // R7: reset in the middle of a stall
    cur_req = "R7";
    @(posedge clk); #0.5;
    acc_valid = 1'b1; addr_top = 2'd2;
    @(posedge clk); #0.5;
    acc_valid = 1'b0;
    repeat (3) @(posedge clk);
    #0.5; rst = 1'b1;
    @(posedge clk); #0.5; rst = 1'b0;
    #0.2;
    check(wait_n === 1'b1, "R7", int'(wait_n), 1);
    repeat (3) @(posedge clk);

    // mixed stream
    cur_req = "R2";
    for (int i = 0; i < 500; i++) begin
      @(posedge clk); #0.5;
      acc_valid = ($urandom_range(0, 2) != 0);
      addr_top  = 2'($urandom_range(0, 3));
      ready     = ($urandom_range(0, 3) != 0);
    end
    @(posedge clk); #0.5;
    acc_valid = 1'b0; ready = 1'b1;
    repeat (20) @(posedge clk);
    #1;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 20000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule